// File: doc/BRIEF.md
# Aligned Block Transfer Segmenter

This block turns one transfer request between main storage and a 256-byte channel data buffer into a train of 8-byte storage beats. A request gives a start byte address in storage, a start byte offset in the buffer, a byte count and a direction. The block cuts the request into segments that never cross a 64-byte storage boundary. Only the head segment and the tail segment can be short, and that happens when the request does not start or end on such a boundary. Each segment is then issued as one beat per clock. Every beat carries the doubleword-aligned storage address, a byte-enable mask for the valid lanes, and the buffer offset of its first valid byte.

Buffer positions and storage positions need not share alignment, because the buffer side is filled one or two bytes at a time. A byte rotator therefore sits on the 8-byte data path. The rotation amount comes from the low three bits of both start positions. The direction of the request sets which way the bytes turn. Buffer offsets wrap modulo 256, so the buffer can be used as a ring. A one-cycle done pulse closes each request.

Top module: `aligned_xfer_seg`

## Requirements
- R1: After synchronous reset, `busy`, `beat_valid`, `done` and `dout` are all zero.
- R2: In the head segment, `seg_len` on the segment's first beat equals min(count, 64 - (address mod 64)).
- R3: Each segment after the head starts on a 64-byte storage boundary, and its `seg_len` on the first beat equals min(bytes remaining, 64). On every beat, `seg_len` is the number of bytes from that beat to the end of its segment.
- R4: If `start` is sampled at rising edge k, `busy` is high after edge k. Beat i (counting from 0) is presented after edge k+1+i, one beat per cycle with no gaps. `beat_addr` is the storage byte address of that beat with its low 3 bits cleared.
- R5: `beat_be` bit j is set exactly when storage lane j (address mod 8 == j) of that beat holds a requested byte. A beat's byte count is min(8 - start lane, bytes remaining).
- R6: `beat_buf_off` equals (buffer offset + bytes issued by earlier beats) mod 256.
- R7: With s = (storage address mod 8 - buffer offset mod 8) mod 8, latched at start, `dout` lane j after a clock edge equals `din` lane (j+s) mod 8 sampled at that edge when `dir`=0 (storage to buffer). It equals `din` lane (j-s) mod 8 when `dir`=1 (buffer to storage). Lane j is bits 8j+7:8j.
- R8: `done` is high for exactly one cycle, after edge k+N+1 for a request of N beats, and no beat is valid in that cycle. A zero count gives no beats and `done` after edge k+1.
- R9: `start` is ignored while `busy` is high. The running request completes unchanged and no further beats follow it.
- R10: `seg_first` marks the first beat of the request and every beat whose address is 64-byte aligned. `seg_last` marks a beat that ends on a 64-byte boundary or that finishes the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when idle |
| dir | input | 1 | 0: storage to buffer, 1: buffer to storage |
| st_addr | input | AW | Storage start byte address |
| buf_off | input | 8 | Buffer start byte offset |
| byte_cnt | input | CW | Number of bytes to move |
| din | input | 64 | Beat data entering the rotator |
| dout | output | 64 | Rotated beat data, one cycle later |
| busy | output | 1 | Request in progress |
| beat_valid | output | 1 | Beat fields are valid this cycle |
| beat_addr | output | AW | Doubleword-aligned storage address of the beat |
| beat_be | output | 8 | Per-lane byte enables of the beat |
| beat_buf_off | output | 8 | Buffer offset of the beat's first valid byte |
| seg_first | output | 1 | Beat opens a segment |
| seg_last | output | 1 | Beat closes a segment |
| seg_len | output | 7 | Bytes from this beat to the end of its segment |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
If `start` is taken at edge k, `busy` rises after edge k. Beat i follows after edge k+1+i, and `done` follows after edge k+N+1. The rotated data trails `din` by exactly one edge. The bench drives inputs on falling edges and sweeps every storage start offset within a 64-byte block against a set of counts and two buffer offsets, one of which forces a wrap. It counts falling edges from the sampled start, so every beat field, the done pulse and the quiet cycle after it are compared at the edge where they are due. The rotation is checked for all 64 pairs of lane offsets in both directions, one falling edge after `din` changes.

// File: rtl/aligned_xfer_seg_pkg.sv
package aligned_xfer_seg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seg_state_e;

  typedef enum logic {
    DIR_TO_BUF   = 1'b0,
    DIR_TO_STORE = 1'b1
  } xfer_dir_e;
endpackage

// File: rtl/xfer_seg_span.sv
// Per-beat length, segment remainder and segment-end detection.
module xfer_seg_span #(
  parameter int CW         = 16,
  parameter int SEG_BYTES  = 64,
  parameter int BEAT_BYTES = 8
) (
  input  logic [$clog2(SEG_BYTES)-1:0]    addr_lo,
  input  logic [CW-1:0]                   rem,
  output logic [$clog2(BEAT_BYTES+1)-1:0] beat_n,
  output logic [$clog2(SEG_BYTES+1)-1:0]  seg_len,
  output logic                            seg_end
);
  localparam int SL = $clog2(SEG_BYTES);
  localparam int BL = $clog2(BEAT_BYTES);
  localparam int SW = $clog2(SEG_BYTES+1);
  localparam int NW = $clog2(BEAT_BYTES+1);

  logic [SW-1:0] room_seg;
  logic [NW-1:0] room_beat;

  assign room_seg  = SW'(SEG_BYTES) - SW'(addr_lo);
  assign room_beat = NW'(BEAT_BYTES) - NW'(addr_lo[BL-1:0]);

  assign seg_len = (rem < CW'(room_seg))  ? SW'(rem) : room_seg;
  assign beat_n  = (rem < CW'(room_beat)) ? NW'(rem) : room_beat;

  // A beat closes its segment when it reaches the boundary or drains the request.
  assign seg_end = ((SW'(addr_lo) + SW'(beat_n)) == SW'(SEG_BYTES)) ||
                   (CW'(beat_n) == rem);
endmodule

// File: rtl/xfer_lane_mask.sv
// Contiguous byte-enable mask from a first lane and a byte count.
module xfer_lane_mask #(
  parameter int BEAT_BYTES = 8
) (
  input  logic [$clog2(BEAT_BYTES)-1:0]   lo,
  input  logic [$clog2(BEAT_BYTES+1)-1:0] n,
  output logic [BEAT_BYTES-1:0]           mask
);
  for (genvar i = 0; i < BEAT_BYTES; i++) begin : g_lane
    assign mask[i] = (32'(i) >= 32'(lo)) && (32'(i) < (32'(lo) + 32'(n)));
  end
endmodule

// File: rtl/xfer_byte_rot.sv
// Byte rotator: direction selects the sense of rotation.
module xfer_byte_rot
  import aligned_xfer_seg_pkg::*;
#(
  parameter int BEAT_BYTES = 8
) (
  input  logic [8*BEAT_BYTES-1:0]       din,
  input  logic [$clog2(BEAT_BYTES)-1:0] shift,
  input  xfer_dir_e                     dir,
  output logic [8*BEAT_BYTES-1:0]       dout
);
  localparam int BL = $clog2(BEAT_BYTES);

  for (genvar j = 0; j < BEAT_BYTES; j++) begin : g_out
    logic [BL-1:0] src;
    assign src = (dir == DIR_TO_STORE) ? (BL'(j) - shift) : (BL'(j) + shift);
    assign dout[8*j +: 8] = din[8*src +: 8];
  end
endmodule

// File: rtl/aligned_xfer_seg.sv
module aligned_xfer_seg
  import aligned_xfer_seg_pkg::*;
#(
  parameter int AW         = 32,
  parameter int CW         = 16,
  parameter int SEG_BYTES  = 64,
  parameter int BEAT_BYTES = 8,
  parameter int BUF_BYTES  = 256
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start,
  input  logic                              dir,
  input  logic [AW-1:0]                     st_addr,
  input  logic [$clog2(BUF_BYTES)-1:0]      buf_off,
  input  logic [CW-1:0]                     byte_cnt,
  input  logic [8*BEAT_BYTES-1:0]           din,
  output logic [8*BEAT_BYTES-1:0]           dout,
  output logic                              busy,
  output logic                              beat_valid,
  output logic [AW-1:0]                     beat_addr,
  output logic [BEAT_BYTES-1:0]             beat_be,
  output logic [$clog2(BUF_BYTES)-1:0]      beat_buf_off,
  output logic                              seg_first,
  output logic                              seg_last,
  output logic [$clog2(SEG_BYTES+1)-1:0]    seg_len,
  output logic                              done
);
  localparam int SL = $clog2(SEG_BYTES);
  localparam int BL = $clog2(BEAT_BYTES);
  localparam int BW = $clog2(BUF_BYTES);
  localparam int SW = $clog2(SEG_BYTES+1);
  localparam int NW = $clog2(BEAT_BYTES+1);
  localparam int DW = 8*BEAT_BYTES;

  seg_state_e     state_q;
  logic [AW-1:0]  cur_addr_q;
  logic [CW-1:0]  rem_q;
  logic [BW-1:0]  bptr_q;
  logic           first_q;
  logic [BL-1:0]  shift_q;
  xfer_dir_e      dir_q;

  logic [NW-1:0]         n_w;
  logic [SW-1:0]         seg_len_w;
  logic                  seg_end_w;
  logic [BEAT_BYTES-1:0] mask_w;
  logic [DW-1:0]         rot_w;

  xfer_seg_span #(
    .CW(CW), .SEG_BYTES(SEG_BYTES), .BEAT_BYTES(BEAT_BYTES)
  ) u_span (
    .addr_lo (cur_addr_q[SL-1:0]),
    .rem     (rem_q),
    .beat_n  (n_w),
    .seg_len (seg_len_w),
    .seg_end (seg_end_w)
  );

  xfer_lane_mask #(.BEAT_BYTES(BEAT_BYTES)) u_mask (
    .lo   (cur_addr_q[BL-1:0]),
    .n    (n_w),
    .mask (mask_w)
  );

  xfer_byte_rot #(.BEAT_BYTES(BEAT_BYTES)) u_rot (
    .din   (din),
    .shift (shift_q),
    .dir   (dir_q),
    .dout  (rot_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      cur_addr_q   <= '0;
      rem_q        <= '0;
      bptr_q       <= '0;
      first_q      <= 1'b0;
      shift_q      <= '0;
      dir_q        <= DIR_TO_BUF;
      dout         <= '0;
      busy         <= 1'b0;
      beat_valid   <= 1'b0;
      beat_addr    <= '0;
      beat_be      <= '0;
      beat_buf_off <= '0;
      seg_first    <= 1'b0;
      seg_last     <= 1'b0;
      seg_len      <= '0;
      done         <= 1'b0;
    end else begin
      dout       <= rot_w;
      beat_valid <= 1'b0;
      done       <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            cur_addr_q <= st_addr;
            rem_q      <= byte_cnt;
            bptr_q     <= buf_off;
            first_q    <= 1'b1;
            shift_q    <= st_addr[BL-1:0] - buf_off[BL-1:0];
            dir_q      <= xfer_dir_e'(dir);
            busy       <= 1'b1;
            state_q    <= (byte_cnt == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          beat_valid   <= 1'b1;
          beat_addr    <= {cur_addr_q[AW-1:BL], {BL{1'b0}}};
          beat_be      <= mask_w;
          beat_buf_off <= bptr_q;
          seg_first    <= first_q || (cur_addr_q[SL-1:0] == '0);
          seg_last     <= seg_end_w;
          seg_len      <= seg_len_w;
          cur_addr_q   <= cur_addr_q + AW'(n_w);
          rem_q        <= rem_q - CW'(n_w);
          bptr_q       <= bptr_q + BW'(n_w);
          first_q      <= 1'b0;
          if (CW'(n_w) == rem_q) state_q <= ST_FIN;
        end
        ST_FIN: begin
          done    <= 1'b1;
          busy    <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aligned_xfer_seg_chk.sv
module aligned_xfer_seg_chk #(
  parameter int AW         = 32,
  parameter int SEG_BYTES  = 64,
  parameter int BEAT_BYTES = 8,
  parameter int BUF_BYTES  = 256
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         busy,
  input logic                         beat_valid,
  input logic [AW-1:0]                beat_addr,
  input logic [BEAT_BYTES-1:0]        beat_be,
  input logic [$clog2(BUF_BYTES)-1:0] beat_buf_off,
  input logic                         seg_first,
  input logic                         done
);
  localparam int SL = $clog2(SEG_BYTES);
  localparam int BW = $clog2(BUF_BYTES);

  p_beat_inside_busy_r4: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> busy);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && $past(beat_valid)) |-> (beat_addr == $past(beat_addr) + AW'(BEAT_BYTES)));

  p_be_nonzero_r5: assert property (@(posedge clk) disable iff (rst)
    beat_valid |-> (beat_be != '0));

  p_buf_step_r6: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && $past(beat_valid)) |->
      (beat_buf_off == BW'($past(beat_buf_off) + BW'($countones($past(beat_be))))));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_no_beat_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !beat_valid);

  p_seg_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && seg_first && $past(beat_valid)) |-> (beat_addr[SL-1:0] == '0));
endmodule

bind aligned_xfer_seg aligned_xfer_seg_chk #(
  .AW(AW), .SEG_BYTES(SEG_BYTES), .BEAT_BYTES(BEAT_BYTES), .BUF_BYTES(BUF_BYTES)
) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .beat_valid   (beat_valid),
  .beat_addr    (beat_addr),
  .beat_be      (beat_be),
  .beat_buf_off (beat_buf_off),
  .seg_first    (seg_first),
  .done         (done)
);

// File: tb/aligned_xfer_seg_tb.sv
`timescale 1ns/1ps
module aligned_xfer_seg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        dir = 1'b0;
  logic [31:0] st_addr = '0;
  logic [7:0]  buf_off = '0;
  logic [15:0] byte_cnt = '0;
  logic [63:0] din = '0;
  logic [63:0] dout;
  logic        busy, beat_valid, seg_first, seg_last, done;
  logic [31:0] beat_addr;
  logic [7:0]  beat_be, beat_buf_off;
  logic [6:0]  seg_len;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  aligned_xfer_seg u_dut (
    .clk(clk), .rst(rst), .start(start), .dir(dir), .st_addr(st_addr),
    .buf_off(buf_off), .byte_cnt(byte_cnt), .din(din), .dout(dout),
    .busy(busy), .beat_valid(beat_valid), .beat_addr(beat_addr),
    .beat_be(beat_be), .beat_buf_off(beat_buf_off), .seg_first(seg_first),
    .seg_last(seg_last), .seg_len(seg_len), .done(done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_xfer(input int a, input int b, input int cnt, input int d, input bit poke);
    int ca = a;
    int rem = cnt;
    int cb = b;
    bit first = 1'b1;
    int seg_no = 0;
    int beat = 0;
    @(negedge clk);
    start = 1'b1; st_addr = 32'(a); buf_off = 8'(b); byte_cnt = 16'(cnt); dir = d[0];
    @(negedge clk);
    start = 1'b0;
    chk("R4 busy after start", 64'(busy), 64'd1);
    while (rem > 0) begin
      int lo, n, room, sl, msk;
      bit sf, sls;
      if (poke && beat == 1) begin
        start = 1'b1; st_addr = 32'h40; buf_off = 8'd0; byte_cnt = 16'd5; dir = 1'b0;
      end
      @(negedge clk);
      start = 1'b0;
      lo   = ca % 8;
      n    = (8 - lo < rem) ? 8 - lo : rem;
      msk  = (((1 << n) - 1) << lo) & 255;
      room = 64 - (ca % 64);
      sl   = (rem < room) ? rem : room;
      sf   = first || (ca % 64 == 0);
      sls  = ((ca % 64) + n == 64) || (n == rem);
      if (sf && !first) seg_no++;
      chk("R4 beat valid", 64'(beat_valid), 64'd1);
      chk("R4 beat addr", 64'(beat_addr), 64'(ca & ~7));
      chk("R5 byte enables", 64'(beat_be), 64'(msk));
      chk("R6 buffer offset", 64'(beat_buf_off), 64'(cb % 256));
      if (seg_no == 0) chk("R2 head seg len", 64'(seg_len), 64'(sl));
      else             chk("R3 seg len", 64'(seg_len), 64'(sl));
      chk("R10 seg first", 64'(seg_first), 64'(sf));
      chk("R10 seg last", 64'(seg_last), 64'(sls));
      ca += n; cb += n; rem -= n; first = 1'b0; beat++;
    end
    @(negedge clk);
    chk("R8 done pulse", 64'(done), 64'd1);
    chk("R8 no beat with done", 64'(beat_valid), 64'd0);
    chk("R8 busy clear", 64'(busy), 64'd0);
    @(negedge clk);
    chk("R8 done one cycle", 64'(done), 64'd0);
    chk("R9 no trailing beat", 64'(beat_valid), 64'd0);
    if (poke) begin
      @(negedge clk);
      chk("R9 start while busy ignored", 64'({busy, beat_valid, done}), 64'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int counts[13] = '{0, 1, 2, 7, 8, 9, 56, 63, 64, 65, 127, 200, 256};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 beat_valid", 64'(beat_valid), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
    chk("R1 dout", dout, 64'd0);

    // R2 R3 R4 R5 R6 R8 R10: sweep start offsets, counts, buffer offsets
    for (int off = 0; off < 64; off++)
      for (int ci = 0; ci < 13; ci++)
        for (int bi = 0; bi < 2; bi++)
          run_xfer(32'h0001_0000 + off, (bi == 0) ? 0 : 250, counts[ci], bi, 1'b0);

    // R9: start pulse during a running request
    run_xfer(32'h0002_0103, 9, 40, 0, 1'b1);

    // R7: rotation for every lane pairing and both directions
    for (int sa = 0; sa < 8; sa++)
      for (int sb = 0; sb < 8; sb++)
        for (int d = 0; d < 2; d++) begin
          logic [63:0] pat, exp;
          int s;
          run_xfer(32'h0003_0000 + sa, 16 + sb, 0, d, 1'b0);
          for (int j = 0; j < 8; j++) pat[8*j +: 8] = 8'(j * 32 + ((sa + sb * 3 + d * 7) & 31));
          s = (sa - sb) & 7;
          for (int j = 0; j < 8; j++) begin
            int src;
            src = (d == 1) ? ((j - s) & 7) : ((j + s) & 7);
            exp[8*j +: 8] = pat[8*src +: 8];
          end
          din = pat;
          @(negedge clk);
          chk("R7 rotation", dout, exp);
        end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule